// File: doc/BRIEF.md
# Count-Driven Constant Field Extractor

This block recovers the per-operation bit fields of up to eight flow slots from one long packed data vector. Each slot descriptor carries two small counts. One says how many extension units the operation owns, the other how many constant units it owns. The units of all slots are packed back to back, with no gaps, in two regions of the data vector.

Field positions are not fixed. Slot k starts where the slots before it end, so the block forms a running sum of the counts across the slots. Slots whose valid bit is clear are skipped in that sum.

The work is split over two registered stages. The first stage forms the prefix sums and registers the offsets together with the counts and the data. The second stage only shifts and masks each field, then registers the result. Each slot's result is right-aligned, zero-extended and paired with a valid flag. The constant field of a constant-load operation is its literal.

Top module: `const_field_extract`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid`, every `out_vld` bit, `out_ext` and `out_con` are zero.
- R2: A descriptor set presented with `in_valid` high at clock edge n produces its results on the outputs after edge n+2. The block accepts a new set on every cycle, with no bubbles.
- R3: The extension region is `blk_data[191:0]`, with unit u at bits [8u+7:8u]. Slot k's extension field starts at the unit equal to the sum of `ext_cnt` over the valid slots below k.
- R4: The constant region is `blk_data[383:192]`, with unit u at bits [192+8u+7:192+8u]. Slot k's constant field starts at the sum of `con_cnt` over the valid slots below k. This offset does not depend on the extension counts.
- R5: Slot k's counts are `ext_cnt[2k+1:2k]` and `con_cnt[2k+1:2k]`, each 0 to 3. Each field is output right-aligned in its 24-bit lane (slot k at bits [24k+23:24k]). Its lowest unit sits at bits 7:0, and bits from 8×count upward are zero. A count of zero gives a zero lane.
- R6: A slot with `slot_vld[k]` low adds nothing to either running sum, outputs `out_vld[k]` low, and outputs zero in both of its lanes.
- R7: A cycle with `in_valid` low yields, two cycles later, `out_valid` low with all flags and lanes zero.
- R8: With all eight slots valid and every count at 3, the regions are consumed exactly. Slot 7 receives units 21 to 23 of each region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Descriptor set present this cycle |
| slot_vld | input | 8 | Per-slot operation valid |
| ext_cnt | input | 16 | Per-slot extension unit count, 2 bits per slot |
| con_cnt | input | 16 | Per-slot constant unit count, 2 bits per slot |
| blk_data | input | 384 | Packed unit data: extension region low, constant region high |
| out_valid | output | 1 | Result set present |
| out_vld | output | 8 | Per-slot result valid |
| out_ext | output | 192 | Per-slot extension field, 24 bits per slot |
| out_con | output | 192 | Per-slot constant field, 24 bits per slot |

## Verification
Several corner cases are targeted directly:
- **Invalid slots wedged between valid ones.** A design that still added their counts would shift every later slot by whole units.
- **Differing extension and constant counts on the same slot.** A design that shared one offset between the two regions would return the wrong constant.
- **Zero counts and full counts of three.** A mask error would leak neighbouring units into the upper bytes, and an off-by-one offset would read past the region end on slot 7.
- **Back-to-back sets mixed with idle cycles.** A latency that was one cycle short or long would pair results with the wrong set.

// File: rtl/const_field_extract.sv
module const_field_extract #(
  parameter int NSLOT  = 8,
  parameter int UNIT_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic [NSLOT-1:0]               slot_vld,
  input  logic [NSLOT*CNT_W-1:0]         ext_cnt,
  input  logic [NSLOT*CNT_W-1:0]         con_cnt,
  input  logic [2*NSLOT*((1<<CNT_W)-1)*UNIT_W-1:0] blk_data,
  output logic                           out_valid,
  output logic [NSLOT-1:0]               out_vld,
  output logic [NSLOT*((1<<CNT_W)-1)*UNIT_W-1:0]   out_ext,
  output logic [NSLOT*((1<<CNT_W)-1)*UNIT_W-1:0]   out_con
);
  localparam int MAXU  = (1 << CNT_W) - 1;
  localparam int FLD_W = MAXU * UNIT_W;
  localparam int REG_W = NSLOT * FLD_W;
  localparam int OFF_W = $clog2(NSLOT * MAXU + 1);

  logic [OFF_W-1:0] e_off [NSLOT];
  logic [OFF_W-1:0] c_off [NSLOT];
  logic [OFF_W-1:0] e_run, c_run;

  always_comb begin
    e_run = '0;
    c_run = '0;
    for (int k = 0; k < NSLOT; k++) begin
      e_off[k] = e_run;
      c_off[k] = c_run;
      if (in_valid && slot_vld[k]) begin
        e_run = e_run + OFF_W'(ext_cnt[k*CNT_W +: CNT_W]);
        c_run = c_run + OFF_W'(con_cnt[k*CNT_W +: CNT_W]);
      end
    end
  end

  logic                 s1_v;
  logic [NSLOT-1:0]     s1_vld;
  logic [OFF_W-1:0]     s1_eoff [NSLOT];
  logic [OFF_W-1:0]     s1_coff [NSLOT];
  logic [CNT_W-1:0]     s1_ecnt [NSLOT];
  logic [CNT_W-1:0]     s1_ccnt [NSLOT];
  logic [2*REG_W-1:0]   s1_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_vld  <= '0;
      s1_data <= '0;
      for (int k = 0; k < NSLOT; k++) begin
        s1_eoff[k] <= '0;
        s1_coff[k] <= '0;
        s1_ecnt[k] <= '0;
        s1_ccnt[k] <= '0;
      end
    end else begin
      s1_v    <= in_valid;
      s1_vld  <= in_valid ? slot_vld : '0;
      s1_data <= blk_data;
      for (int k = 0; k < NSLOT; k++) begin
        s1_eoff[k] <= e_off[k];
        s1_coff[k] <= c_off[k];
        s1_ecnt[k] <= (in_valid && slot_vld[k]) ? ext_cnt[k*CNT_W +: CNT_W] : '0;
        s1_ccnt[k] <= (in_valid && slot_vld[k]) ? con_cnt[k*CNT_W +: CNT_W] : '0;
      end
    end
  end

  logic [FLD_W-1:0] e_fld [NSLOT];
  logic [FLD_W-1:0] c_fld [NSLOT];

  for (genvar k = 0; k < NSLOT; k++) begin : g_sel
    logic [REG_W-1:0] e_sh, c_sh;
    logic [FLD_W-1:0] e_msk, c_msk;
    assign e_sh  = s1_data[REG_W-1:0] >> (32'(s1_eoff[k]) * UNIT_W);
    assign c_sh  = s1_data[2*REG_W-1:REG_W] >> (32'(s1_coff[k]) * UNIT_W);
    assign e_msk = {FLD_W{1'b1}} >> (FLD_W - 32'(s1_ecnt[k]) * UNIT_W);
    assign c_msk = {FLD_W{1'b1}} >> (FLD_W - 32'(s1_ccnt[k]) * UNIT_W);
    assign e_fld[k] = e_sh[FLD_W-1:0] & e_msk;
    assign c_fld[k] = c_sh[FLD_W-1:0] & c_msk;

    assert_inv_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld[k] |-> (out_ext[k*FLD_W +: FLD_W] == '0 && out_con[k*FLD_W +: FLD_W] == '0));

    assert_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_con[k*FLD_W +: FLD_W] >> (32'($past(s1_ccnt[k])) * UNIT_W)) == '0) &&
      ((out_ext[k*FLD_W +: FLD_W] >> (32'($past(s1_ecnt[k])) * UNIT_W)) == '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vld   <= '0;
      out_ext   <= '0;
      out_con   <= '0;
    end else begin
      out_valid <= s1_v;
      out_vld   <= s1_vld;
      for (int k = 0; k < NSLOT; k++) begin
        out_ext[k*FLD_W +: FLD_W] <= e_fld[k];
        out_con[k*FLD_W +: FLD_W] <= c_fld[k];
      end
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_v);
  assert_emit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |=> out_valid);
  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_vld == '0);
  assert_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |-> ({1'b0, s1_eoff[NSLOT-1]} + (OFF_W+1)'(s1_ecnt[NSLOT-1]) <= (OFF_W+1)'(NSLOT*MAXU)) &&
             ({1'b0, s1_coff[NSLOT-1]} + (OFF_W+1)'(s1_ccnt[NSLOT-1]) <= (OFF_W+1)'(NSLOT*MAXU)));
endmodule

// File: tb/test_const_field_extract.sv
module test_const_field_extract;
  localparam int NS = 8;
  localparam int FW = 24;
  localparam int RW = NS * FW;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic [NS-1:0] slot_vld = '0;
  logic [2*NS-1:0] ext_cnt = '0, con_cnt = '0;
  logic [2*RW-1:0] blk_data = '0;
  logic out_valid;
  logic [NS-1:0] out_vld;
  logic [RW-1:0] out_ext, out_con;

  const_field_extract i_const_field_extract (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .slot_vld(slot_vld),
    .ext_cnt(ext_cnt), .con_cnt(con_cnt), .blk_data(blk_data),
    .out_valid(out_valid), .out_vld(out_vld), .out_ext(out_ext), .out_con(out_con));

  always #2.5 clk = ~clk;

  typedef struct {
    logic [NS-1:0] vld;
    logic [RW-1:0] ext;
    logic [RW-1:0] con;
    int            cyc;
    string         tag;
  } item_t;

  item_t sb[$];
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] pick(input logic [RW-1:0] region, input int off, input int cnt);
    logic [RW-1:0] sh;
    sh = region >> (off * 8);
    return sh[FW-1:0] & ((FW'(1) << (cnt * 8)) - FW'(1));
  endfunction

  task automatic send(input logic [NS-1:0] v, input logic [2*NS-1:0] ec, input logic [2*NS-1:0] cc,
                      input logic [2*RW-1:0] d, input string tag);
    item_t it;
    int eo = 0, co = 0;
    @(negedge clk);
    in_valid = 1; slot_vld = v; ext_cnt = ec; con_cnt = cc; blk_data = d;
    it.vld = v; it.ext = '0; it.con = '0; it.cyc = cyc; it.tag = tag;
    for (int k = 0; k < NS; k++) begin
      if (v[k]) begin
        it.ext[k*FW +: FW] = pick(d[RW-1:0], eo, int'(ec[2*k +: 2]));
        it.con[k*FW +: FW] = pick(d[2*RW-1:RW], co, int'(cc[2*k +: 2]));
        eo += int'(ec[2*k +: 2]);
        co += int'(cc[2*k +: 2]);
      end
    end
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; slot_vld = $urandom; ext_cnt = $urandom; con_cnt = $urandom;
  endtask

  function automatic logic [2*RW-1:0] rnd_data();
    logic [2*RW-1:0] d;
    for (int i = 0; i < 2*RW/32; i++) d[i*32 +: 32] = $urandom;
    return d;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(0, "R2", RW'(out_vld), '0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(cyc == it.cyc + 2, {"R2 ", it.tag}, RW'(cyc), RW'(it.cyc + 2));
          check(out_vld == it.vld, {"R6 ", it.tag}, RW'(out_vld), RW'(it.vld));
          check(out_ext == it.ext, {"R3 ", it.tag}, out_ext, it.ext);
          check(out_con == it.con, {"R4 ", it.tag}, out_con, it.con);
        end
      end else begin
        check(out_vld == '0 && out_ext == '0 && out_con == '0, "R7 idle",
              out_ext | out_con | RW'(out_vld), '0);
      end
    end
  end

  initial begin
    #(5ns * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2*RW-1:0] seq;
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_vld == '0 && out_ext == '0 && out_con == '0, "R1 in reset",
          out_ext | out_con | RW'(out_vld) | RW'(out_valid), '0);
    rst_n = 1;
    @(posedge clk); #1;
    check(out_valid == 0 && out_vld == '0 && out_ext == '0 && out_con == '0, "R1 after reset",
          out_ext | out_con | RW'(out_vld) | RW'(out_valid), '0);

    for (int i = 0; i < 2*RW/8; i++) seq[i*8 +: 8] = 8'(i + 1);

    send(8'h01, 16'h0002, 16'h0003, seq, "R5 single slot");
    send(8'hFF, 16'h0000, 16'h0000, seq, "R5 all counts zero");
    send(8'hFF, 16'hFFFF, 16'hFFFF, seq, "R8 full packing");
    send(8'hFF, 16'h5555, 16'hAAAA, seq, "R4 differing counts");
    send(8'hA5, 16'hFFFF, 16'h7E1B, seq, "R6 holes");
    idle();
    send(8'h00, 16'hFFFF, 16'hFFFF, seq, "R6 none valid");
    idle();
    idle();
    send(8'hFE, 16'h1B6C, 16'hE4E4, seq, "R3 slot0 invalid");
    for (int n = 0; n < 200; n++) begin
      if ($urandom % 4 == 0) idle();
      else send(8'($urandom), 16'($urandom), 16'($urandom), rnd_data(), "R3 random");
    end
    send(8'hFF, 16'hFFFF, 16'hFFFF, rnd_data(), "R8 full random");
    idle();
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R2 drained", RW'(sb.size()), '0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule